// File: doc/BRIEF.md
# Thermal Throttle Controller

This block protects the core from overheating without software in the loop. It watches a digital over-temperature flag from an on-die sensor. When the flag is seen and the mechanism is enabled, the block remembers the operating point then in force. It then asks a voltage/frequency transition sequencer to move to a safer point, which software programmed beforehand.

Once that move completes, the block holds the low point for a programmable number of cycles and then samples the flag again. If the die has cooled, it asks the sequencer to restore the remembered point. If the die is still hot, it starts another hold period. Each completed move, downward and upward, sets its own sticky interrupt cause bit. Software clears a cause bit by writing one to it.

The controller is a five-state machine:
- `ST_IDLE` is the rest state.
- `ST_DEFER` means an over-temperature event was seen while a software transition is still in flight.
- `ST_DROP` requests the low point.
- `ST_DWELL` holds the low point while the timer runs.
- `ST_RAISE` requests the saved point.

The transitions are:
- `ST_IDLE` goes to `ST_DROP` on hot with no software transition in flight. It goes to `ST_DEFER` on hot while a software transition is busy.
- `ST_DEFER` goes to `ST_DROP` when the software transition finishes. It returns to `ST_IDLE` if the enable is cleared.
- `ST_DROP` goes to `ST_DWELL` on done.
- `ST_DWELL` returns to `ST_DWELL` (timer reloaded) when the hold period ends with the die still hot. It goes to `ST_RAISE` when the hold period ends with the die cool.
- `ST_RAISE` goes to `ST_IDLE` on done.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset, `xreq`, `throttled` and `irq` are low and `irq_cause` is 2'b00.
- R2: While enabled and idle with no software transition busy, a synchronized hot flag raises `xreq`. The target on `xreq_opp` is `cfg_low_opp` as sampled when the request starts. `xreq` and `xreq_opp` hold steady until `xdone`, even if `cfg_low_opp` changes meanwhile.
- R3: While `sw_busy` is high and no throttle episode is under way, no request is issued. The request is issued once `sw_busy` falls.
- R4: With `cfg_enable` low and no episode under way, the hot flag is ignored: `xreq` and `throttled` stay low.
- R5: `xdone` during the downward request sets `irq_cause[0]` (down cause).
- R6: After the down move completes, the flag is evaluated once the low point has been held for `cfg_hold_cycles`+1 cycles. If the die is cool, an upward request is issued. Its target is the value `cur_opp` had when the downward request started.
- R7: If the die is still hot at the evaluation, the block stays at the low point for another `cfg_hold_cycles`+1 cycles before it evaluates again.
- R8: `xdone` during the upward request sets `irq_cause[1]` (up cause) and ends the episode (`throttled` low).
- R9: Cause bits stay set until a one is written to the matching bit of `irq_clr`. When a bit is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when any cause bit is set.
- R11: `hot_async` passes through two synchronizing flops. From idle, `xreq` rises on the third rising clock edge after the flag goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hot_async | input | 1 | Over-temperature flag from the sensor, asynchronous |
| cfg_enable | input | 1 | Enables automatic throttling |
| cfg_low_opp | input | OPP_W | Operating point to throttle to |
| cfg_hold_cycles | input | HOLD_W | Hold period at the low point, minus one |
| cur_opp | input | OPP_W | Operating point currently in force |
| sw_busy | input | 1 | A software-initiated transition is in flight |
| xreq | output | 1 | Transition request to the sequencer |
| xreq_opp | output | OPP_W | Target operating point of the request |
| xdone | input | 1 | Sequencer reports the requested transition complete |
| irq_clr | input | 2 | Write-one-to-clear strobes for the cause bits |
| irq_cause | output | 2 | Sticky causes: bit 0 down move, bit 1 up move |
| irq | output | 1 | Interrupt, OR of the cause bits |
| throttled | output | 1 | High from the down request until the up move completes |

## Verification
The hardest path to reach from the ports is the reheat loop. The flag must still read hot through the synchronizer at the first evaluation and read cool at the second, and both evaluations are timed by the internal counter. The stimulus keeps the flag high for a known number of cycles into the hold and then drops it. Because of the two-flop latency, the first evaluation still sees hot and the second sees cool. The length of the low-point stay is then measured as the gap between the end of the down request and the start of the up request, which must be exactly two hold periods. The deferred path is reached by holding `sw_busy` across the hot event and changing `cur_opp` before releasing it, which shows which value was saved.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_DROP,
        ST_DWELL,
        ST_RAISE
    } thr_state_e;

    localparam int CAUSE_W    = 2;
    localparam int CAUSE_DOWN = 0;
    localparam int CAUSE_UP   = 1;

endpackage

// File: rtl/thr_sync2.sv
module thr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[0], d_async};
    end

    assign q_sync = stage[1];
endmodule

// File: rtl/thr_dwell_timer.sv
module thr_dwell_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expired
);
    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/thr_cause_reg.sv
module thr_cause_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o
);
    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_o <= '0;
        else        cause_o <= (cause_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int OPP_W  = 6,
    parameter int HOLD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hot_async,
    input  logic                 cfg_enable,
    input  logic [OPP_W-1:0]     cfg_low_opp,
    input  logic [HOLD_W-1:0]    cfg_hold_cycles,
    input  logic [OPP_W-1:0]     cur_opp,
    input  logic                 sw_busy,
    output logic                 xreq,
    output logic [OPP_W-1:0]     xreq_opp,
    input  logic                 xdone,
    input  logic [CAUSE_W-1:0]   irq_clr,
    output logic [CAUSE_W-1:0]   irq_cause,
    output logic                 irq,
    output logic                 throttled
);
    thr_state_e         state_q, state_d;
    logic               hot_s;
    logic               dwell_expired;
    logic               timer_load;
    logic [OPP_W-1:0]   saved_opp_q;
    logic [OPP_W-1:0]   target_q;
    logic               start_drop;
    logic               start_raise;
    logic [CAUSE_W-1:0] cause_set;

    thr_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hot_async),
        .q_sync  (hot_s)
    );

    thr_dwell_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (cfg_hold_cycles),
        .expired  (dwell_expired)
    );

    thr_cause_reg #(.W(CAUSE_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cause_set),
        .clr_i   (irq_clr),
        .cause_o (irq_cause)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and internal strobes
    always_comb begin
        state_d     = state_q;
        start_drop  = 1'b0;
        start_raise = 1'b0;
        timer_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_enable && hot_s) begin
                    if (sw_busy) begin
                        state_d = ST_DEFER;
                    end else begin
                        state_d    = ST_DROP;
                        start_drop = 1'b1;
                    end
                end
            end
            ST_DEFER: begin
                if (!cfg_enable) begin
                    state_d = ST_IDLE;
                end else if (!sw_busy) begin
                    state_d    = ST_DROP;
                    start_drop = 1'b1;
                end
            end
            ST_DROP: begin
                if (xdone) begin
                    state_d    = ST_DWELL;
                    timer_load = 1'b1;
                end
            end
            ST_DWELL: begin
                if (dwell_expired) begin
                    if (hot_s) begin
                        timer_load = 1'b1;
                    end else begin
                        state_d     = ST_RAISE;
                        start_raise = 1'b1;
                    end
                end
            end
            ST_RAISE: begin
                if (xdone) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // saved and target operating points
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_opp_q <= '0;
            target_q    <= '0;
        end else if (start_drop) begin
            saved_opp_q <= cur_opp;
            target_q    <= cfg_low_opp;
        end else if (start_raise) begin
            target_q    <= saved_opp_q;
        end
    end

    // outputs
    always_comb begin
        xreq      = (state_q == ST_DROP) || (state_q == ST_RAISE);
        xreq_opp  = target_q;
        throttled = (state_q == ST_DROP) || (state_q == ST_DWELL) ||
                    (state_q == ST_RAISE);
        cause_set = '0;
        cause_set[CAUSE_DOWN] = (state_q == ST_DROP)  && xdone;
        cause_set[CAUSE_UP]   = (state_q == ST_RAISE) && xdone;
        irq       = |irq_cause;
    end

endmodule

// File: rtl/thr_ctrl_chk.sv
module thr_ctrl_chk #(
    parameter int OPP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             sw_busy,
    input logic             xreq,
    input logic [OPP_W-1:0] xreq_opp,
    input logic             xdone,
    input logic [1:0]       irq_clr,
    input logic [1:0]       irq_cause,
    input logic             throttled
);
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xreq && !xdone) |=> (xreq && $stable(xreq_opp)));

    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_busy && !throttled) |=> !xreq);

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !throttled) |=> !xreq);

    p_down_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xreq && xdone && throttled && !irq_cause[0]) |=> irq_cause[0] || !throttled);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cause[0] && !irq_clr[0]) |=> irq_cause[0]);

    p_up_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cause[1]) |-> !throttled);
endmodule

bind thermal_throttle_ctrl thr_ctrl_chk #(.OPP_W(OPP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .sw_busy    (sw_busy),
    .xreq       (xreq),
    .xreq_opp   (xreq_opp),
    .xdone      (xdone),
    .irq_clr    (irq_clr),
    .irq_cause  (irq_cause),
    .throttled  (throttled)
);

// File: tb/sim_thermal_throttle_ctrl.sv
module sim_thermal_throttle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OPP_W  = 6;
    localparam int HOLD_W = 16;

    // episode table: {low_opp, cur_opp, hold}
    localparam int N_EP = 4;
    localparam logic [19:0] EPISODES [N_EP] = '{
        {6'd3,  6'd40, 8'd2},
        {6'd0,  6'd63, 8'd4},
        {6'd17, 6'd9,  8'd7},
        {6'd5,  6'd33, 8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hot_async = 1'b0;
    logic cfg_enable = 1'b0;
    logic [OPP_W-1:0]  cfg_low_opp = '0;
    logic [HOLD_W-1:0] cfg_hold_cycles = '0;
    logic [OPP_W-1:0]  cur_opp = '0;
    logic sw_busy = 1'b0;
    logic xdone = 1'b0;
    logic [1:0] irq_clr = '0;
    logic xreq;
    logic [OPP_W-1:0] xreq_opp;
    logic [1:0] irq_cause;
    logic irq;
    logic throttled;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_throttle_ctrl #(.OPP_W(OPP_W), .HOLD_W(HOLD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .hot_async(hot_async),
        .cfg_enable(cfg_enable), .cfg_low_opp(cfg_low_opp),
        .cfg_hold_cycles(cfg_hold_cycles), .cur_opp(cur_opp),
        .sw_busy(sw_busy), .xreq(xreq), .xreq_opp(xreq_opp),
        .xdone(xdone), .irq_clr(irq_clr), .irq_cause(irq_cause),
        .irq(irq), .throttled(throttled)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // waits for xreq; returns number of negedges waited
    task automatic wait_req(output int waited);
        waited = 0;
        while (!xreq && waited < 50) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // one full episode; hot_keep>0 keeps the flag high that many dwell cycles
    task automatic episode(input logic [5:0] lo, input logic [5:0] cu,
                           input int hold, input int hot_keep, input int exp_dwell);
        int waited;
        int n;
        cfg_low_opp = lo;
        cur_opp = cu;
        cfg_hold_cycles = HOLD_W'(hold);
        hot_async = 1'b1;
        wait_req(waited);
        check(waited == 3, "R11 request latency", waited, 3);
        check(xreq_opp == lo, "R2 down target", int'(xreq_opp), int'(lo));
        xdone = 1'b1;
        if (hot_keep == 0) hot_async = 1'b0;
        @(negedge clk);
        xdone = 1'b0;
        check(irq_cause == 2'b01, "R5 down cause", int'(irq_cause), 1);
        check(irq == 1'b1, "R10 irq on cause", int'(irq), 1);
        n = 0;
        while (!xreq && n < 10000) begin
            n++;
            if (hot_keep > 0 && n == hot_keep) hot_async = 1'b0;
            irq_clr = (n == 1) ? 2'b01 : 2'b00;
            if (n == 2) begin
                check(irq_cause == 2'b00, "R9 w1c clear", int'(irq_cause), 0);
                check(irq == 1'b0, "R10 irq low", int'(irq), 0);
            end
            @(negedge clk);
        end
        irq_clr = 2'b00;
        check(n == exp_dwell, (hot_keep > 0) ? "R7 reheat dwell" : "R6 dwell length",
              n, exp_dwell);
        check(xreq_opp == cu, "R6 restore target", int'(xreq_opp), int'(cu));
        // done plus same-cycle clear of the up bit: set must win
        xdone = 1'b1;
        irq_clr = 2'b10;
        @(negedge clk);
        xdone = 1'b0;
        irq_clr = 2'b00;
        check(irq_cause == 2'b10, "R8 up cause, R9 set beats clear", int'(irq_cause), 2);
        check(throttled == 1'b0 && xreq == 1'b0, "R8 episode end", int'(throttled), 0);
        irq_clr = 2'b10;
        @(negedge clk);
        irq_clr = 2'b00;
        check(irq_cause == 2'b00, "R9 clear up", int'(irq_cause), 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        int waited;
        logic [5:0] held;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(xreq == 1'b0, "R1 xreq", int'(xreq), 0);
        check(irq_cause == 2'b00 && irq == 1'b0, "R1 irq", int'(irq_cause), 0);
        check(throttled == 1'b0, "R1 throttled", int'(throttled), 0);
        rst_n = 1'b1;
        cfg_enable = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < N_EP; i++) begin
            episode(EPISODES[i][19:14], EPISODES[i][13:8],
                    int'(EPISODES[i][7:0]), 0, int'(EPISODES[i][7:0]) + 1);
        end

        // R7 reheat: hold 5, flag stays hot into the first evaluation
        episode(6'd2, 6'd50, 5, 8, 12);

        // R4 disabled: flag ignored
        cfg_enable = 1'b0;
        hot_async = 1'b1;
        repeat (10) @(negedge clk);
        check(xreq == 1'b0 && throttled == 1'b0, "R4 ignored when disabled", int'(xreq), 0);
        hot_async = 1'b0;
        repeat (3) @(negedge clk);
        cfg_enable = 1'b1;
        @(negedge clk);

        // R3 deferral, saved point sampled at release; R2 target latch
        sw_busy = 1'b1;
        cur_opp = 6'd20;
        cfg_low_opp = 6'd7;
        cfg_hold_cycles = 16'd2;
        hot_async = 1'b1;
        repeat (8) @(negedge clk);
        check(xreq == 1'b0, "R3 held while busy", int'(xreq), 0);
        cur_opp = 6'd44;
        sw_busy = 1'b0;
        @(negedge clk);
        check(xreq == 1'b1, "R3 issued after busy", int'(xreq), 1);
        held = xreq_opp;
        cfg_low_opp = 6'd30;
        repeat (3) @(negedge clk);
        check(xreq == 1'b1 && xreq_opp == held && held == 6'd7, "R2 target stable",
              int'(xreq_opp), 7);
        xdone = 1'b1;
        hot_async = 1'b0;
        @(negedge clk);
        xdone = 1'b0;
        wait_req(waited);
        check(xreq_opp == 6'd44, "R3 saved point at release", int'(xreq_opp), 44);
        xdone = 1'b1;
        @(negedge clk);
        xdone = 1'b0;
        irq_clr = 2'b11;
        @(negedge clk);
        irq_clr = 2'b00;
        check(irq_cause == 2'b00 && throttled == 1'b0, "R9 final clear", int'(irq_cause), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule